// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between four device interrupt request lines and a processor. Each device has its own service routine. The controller holds every request until it is acknowledged. It picks one winner under a fixed priority and raises a single request line to the processor. When the processor acknowledges, the controller returns the start address of the winning device's routine.

The controller keeps an in-service register with one bit per level. Accepting an interrupt clears the global enable, which masks further interrupts. Software may set the enable again inside a routine to allow nesting. While a level is in service, only a request of strictly higher priority can reach the processor. A return pulse ends the most urgent level in service. Saving processor state is left to the processor.

Top module: `pic_top`

## Requirements
- R1: After reset, `intr_o` is 0, `vector_o` is 0, `isr_o` is 0 and the global enable is off.
- R2: A request that is high on any rising clock edge is latched as pending and stays pending after the line drops, until that request is acknowledged.
- R3: `intr_o` is high only when the global enable is on and at least one pending request is eligible. It follows the registered state and reacts in the cycle after the edge that changes that state.
- R4: Among eligible pending requests the lowest request number wins: request 0 has the highest priority and request 3 the lowest.
- R5: An edge with `inta_i` and `intr_o` both high loads `vector_o` with the winner's routine address. The addresses for requests 0, 1, 2 and 3 are 4, 20, 170 and 240. `vector_o` holds its value until the next accepted acknowledge.
- R6: An accepted acknowledge clears the winner's pending bit, sets bit n of `isr_o` for winner n, and turns the global enable off.
- R7: An `en_cmd_i` pulse turns the global enable on and a `dis_cmd_i` pulse turns it off. Disable wins over enable in the same cycle, and an accepted acknowledge wins over enable in the same cycle.
- R8: While `isr_o` is non-zero, only requests numbered below the lowest set bit of `isr_o` are eligible.
- R9: A `reti_i` pulse clears the lowest-numbered set bit of `isr_o`. With `isr_o` at zero it has no effect.
- R10: `inta_i` while `intr_o` is low is ignored: `vector_o`, `isr_o` and the pending requests stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 4 | Device request lines, bit n is request n |
| en_cmd_i | input | 1 | Global enable command pulse |
| dis_cmd_i | input | 1 | Global disable command pulse |
| inta_i | input | 1 | Acknowledge from the processor |
| reti_i | input | 1 | Return-from-interrupt pulse |
| intr_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Routine address of the last accepted interrupt |
| isr_o | output | 4 | In-service levels, bit n is request n |

## Verification
The bench targets nesting in both directions. A lower-priority request that arrives while a level is in service must stay invisible even with the enable on. A design that compares against the wrong end of the in-service register would preempt, or would block a more urgent device. Returns are checked one level at a time, so a return that clears every level, or the wrong level, shows up as a wrong `isr_o` or an early request. Enable conflicts in the same cycle (disable against enable, acknowledge against enable) and an acknowledge with no request pending are also driven. A design that resolves these the other way raises a request when it should not, or corrupts the vector.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PIC_N_IRQ = 4;
    localparam int PIC_VEC_W = 8;
    // routine start addresses, request 0 in the low slice
    localparam logic [PIC_N_IRQ*PIC_VEC_W-1:0] PIC_VEC_TABLE =
        {8'd240, 8'd170, 8'd20, 8'd4};
endpackage

// File: rtl/pic_prio_enc.sv
// Fixed-priority picker: the lowest set index wins.
module pic_prio_enc #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] onehot,
    output logic         any
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == 0) begin : g_top
            assign onehot[i] = req[i];
        end else begin : g_rest
            assign onehot[i] = req[i] & ~(|req[i-1:0]);
        end
    end
    assign any = |req;
endmodule

// File: rtl/pic_vec_sel.sv
// AND-OR selection of a routine address from a one-hot winner.
module pic_vec_sel #(
    parameter int                   N     = 4,
    parameter int                   VW    = 8,
    parameter logic [N*VW-1:0]      TABLE = '0
) (
    input  logic [N-1:0]  sel_oh,
    output logic [VW-1:0] vec
);
    logic [VW-1:0] part [N];
    for (genvar i = 0; i < N; i++) begin : g_slot
        assign part[i] = sel_oh[i] ? TABLE[i*VW +: VW] : '0;
    end
    always_comb begin
        vec = '0;
        for (int i = 0; i < N; i++) vec = vec | part[i];
    end
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int                          N_IRQ     = PIC_N_IRQ,
    parameter int                          VEC_W     = PIC_VEC_W,
    parameter logic [N_IRQ*VEC_W-1:0]      VEC_TABLE = PIC_VEC_TABLE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic             en_cmd_i,
    input  logic             dis_cmd_i,
    input  logic             inta_i,
    input  logic             reti_i,
    output logic             intr_o,
    output logic [VEC_W-1:0] vector_o,
    output logic [N_IRQ-1:0] isr_o
);
    typedef struct packed {
        logic [N_IRQ-1:0] pend;
        logic [N_IRQ-1:0] isr;
        logic             ien;
        logic [VEC_W-1:0] vec;
    } pic_state_t;

    pic_state_t st_d, st_q;

    logic [N_IRQ-1:0] isr_low_oh;
    logic             isr_any;
    logic [N_IRQ-1:0] prio_mask;
    logic [N_IRQ-1:0] elig;
    logic [N_IRQ-1:0] win_oh;
    logic             win_any;
    logic [VEC_W-1:0] win_vec;
    logic             ack;
    logic             ien_q;

    // most urgent level currently in service
    pic_prio_enc #(.N(N_IRQ)) u_isr_low (
        .req    (st_q.isr),
        .onehot (isr_low_oh),
        .any    (isr_any)
    );

    // only levels strictly more urgent than the one in service may compete
    assign prio_mask = isr_any ? (isr_low_oh - 1'b1) : '1;
    assign elig      = st_q.pend & prio_mask;

    pic_prio_enc #(.N(N_IRQ)) u_win (
        .req    (elig),
        .onehot (win_oh),
        .any    (win_any)
    );

    pic_vec_sel #(.N(N_IRQ), .VW(VEC_W), .TABLE(VEC_TABLE)) u_vec (
        .sel_oh (win_oh),
        .vec    (win_vec)
    );

    assign intr_o = st_q.ien & win_any;
    assign ack    = inta_i & intr_o;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend | irq_i) & ~(ack ? win_oh : '0);
        if (en_cmd_i)  st_d.ien = 1'b1;
        if (dis_cmd_i) st_d.ien = 1'b0;
        if (ack)       st_d.ien = 1'b0;
        if (reti_i)    st_d.isr = st_d.isr & ~isr_low_oh;
        if (ack) begin
            st_d.isr = st_d.isr | win_oh;
            st_d.vec = win_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vector_o = st_q.vec;
    assign isr_o    = st_q.isr;
    assign ien_q    = st_q.ien;
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
    parameter int N_IRQ = 4,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inta_i,
    input logic             reti_i,
    input logic             dis_cmd_i,
    input logic             intr_o,
    input logic [VEC_W-1:0] vector_o,
    input logic [N_IRQ-1:0] isr_o,
    input logic             ien_q
);
    AST_INTR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |-> !intr_o); // R3

    AST_ACK_ADDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && intr_o && !reti_i) |=> ($countones(isr_o) == $countones($past(isr_o)) + 1)); // R6

    AST_ACK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && intr_o) |=> !ien_q); // R6

    AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cmd_i |=> !ien_q); // R7

    AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(inta_i && intr_o) |=> $stable(vector_o)); // R5

    AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && !intr_o && !reti_i) |=> $stable(isr_o)); // R10

    AST_RETI_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !(inta_i && intr_o) && (isr_o != '0))
            |=> ($countones(isr_o) + 1 == $countones($past(isr_o)))); // R9
endmodule

bind pic_top pic_chk #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inta_i    (inta_i),
    .reti_i    (reti_i),
    .dis_cmd_i (dis_cmd_i),
    .intr_o    (intr_o),
    .vector_o  (vector_o),
    .isr_o     (isr_o),
    .ien_q     (ien_q)
);

// File: tb/tb_pic_top.sv
`timescale 1ns/1ps
module tb_pic_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] irq;
    logic       en_cmd, dis_cmd, inta, reti;
    logic       intr;
    logic [7:0] vec;
    logic [3:0] isr;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pic_top dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .en_cmd_i(en_cmd),
        .dis_cmd_i(dis_cmd), .inta_i(inta), .reti_i(reti),
        .intr_o(intr), .vector_o(vec), .isr_o(isr)
    );

    // {requests, expected address, expected in-service}
    localparam logic [15:0] TBL [8] = '{
        {4'b0001, 8'd4,   4'b0001},
        {4'b0010, 8'd20,  4'b0010},
        {4'b0100, 8'd170, 4'b0100},
        {4'b1000, 8'd240, 4'b1000},
        {4'b1111, 8'd4,   4'b0001},
        {4'b1100, 8'd170, 4'b0100},
        {4'b1010, 8'd20,  4'b0010},
        {4'b0110, 8'd20,  4'b0010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        irq = '0; en_cmd = 0; dis_cmd = 0; inta = 0; reti = 0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        step();
        rst_n = 1;
        step();
    endtask

    task automatic pulse_irq(input logic [3:0] m);
        irq = m; step(); irq = '0;
    endtask

    task automatic pulse_en();
        en_cmd = 1; step(); en_cmd = 0;
    endtask

    task automatic pulse_ack();
        inta = 1; step(); inta = 0;
    endtask

    task automatic pulse_reti();
        reti = 1; step(); reti = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1 intr", intr, 0);
        check("R1 vector", vec, 0);
        check("R1 isr", isr, 0);

        // table walk: priority and vectors
        for (int k = 0; k < 8; k++) begin
            do_reset();
            pulse_irq(TBL[k][15:12]);
            pulse_en();
            check("R3 intr after enable", intr, 1);
            pulse_ack();
            check("R5 vector", vec, TBL[k][11:4]);
            check("R4 in-service winner", isr, TBL[k][3:0]);
            check("R6 intr masked after ack", intr, 0);
        end

        // latching while disabled, enable/disable commands
        do_reset();
        pulse_irq(4'b0100);
        step();
        check("R3 no intr while disabled", intr, 0);
        en_cmd = 1; dis_cmd = 1; step(); idle();
        check("R7 disable wins", intr, 0);
        pulse_en();
        check("R2 pending kept", intr, 1);
        dis_cmd = 1; step(); idle();
        check("R7 disable", intr, 0);

        // nesting
        pulse_en();
        pulse_ack();
        check("R5 vector lvl2", vec, 170);
        check("R6 isr lvl2", isr, 4'b0100);
        pulse_irq(4'b1000);
        pulse_en();
        check("R8 lower request blocked", intr, 0);
        pulse_irq(4'b0010);
        check("R8 higher request passes", intr, 1);
        pulse_ack();
        check("R5 nested vector", vec, 20);
        check("R8 nested isr", isr, 4'b0110);
        pulse_reti();
        check("R9 reti clears lvl1", isr, 4'b0100);
        pulse_en();
        check("R8 lvl3 still blocked", intr, 0);
        pulse_reti();
        check("R9 reti clears lvl2", isr, 4'b0000);
        check("R8 lvl3 released", intr, 1);
        pulse_ack();
        check("R5 vector lvl3", vec, 240);
        pulse_reti();
        check("R9 isr empty", isr, 0);
        pulse_reti();
        check("R9 reti on empty", isr, 0);

        // stray acknowledge
        pulse_irq(4'b0001);
        pulse_ack();
        check("R10 vector kept", vec, 240);
        check("R10 isr kept", isr, 0);
        pulse_en();
        check("R10 pending kept", intr, 1);

        // acknowledge beats enable in the same cycle
        inta = 1; en_cmd = 1; step(); idle();
        check("R6 isr lvl0", isr, 4'b0001);
        pulse_irq(4'b0001);
        pulse_reti();
        check("R7 ack wins over enable", intr, 0);
        pulse_en();
        check("R2 request relatched", intr, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule